// File: doc/BRIEF.md
# Persistence-Filtered Hysteresis Limit Monitor

This block watches one sampled telemetry channel, such as a temperature, a bias current or a detected power level, and decides whether that channel is in fault. On every valid sample strobe it compares the reading with two programmable limits. The trip limit decides when a reading counts as bad. The release limit decides when a reading counts as recovered. A fault is declared only after a programmable run of consecutive bad readings. Once declared, it is withdrawn only after the same number of consecutive readings inside the release limit. A larger run count suppresses more nuisance trips, but detection then takes longer: about the run count times the sample interval.

The monitor only reads sample values and never drives the observed signal. It presents two outputs. The raw compare flag shows the trip comparison of the latest sample. The fault flag is the filtered result. A small write-only register port loads the limits, the run count and the direction bit. A synchronous clear restarts the filter without touching the configuration. The parameter `SIGNED_CMP` selects whether readings and limits are compared as two's-complement or unsigned numbers; the default is unsigned.

Top module: `lmon_top`

## Requirements
- R1: Configuration writes (`cfg_we` high) take effect in the next cycle. Register addresses are: 0 = trip limit, 1 = release limit, 2 = run count (low `CNT_W` bits), 3 = direction (bit 0). After reset both limits are all ones, the run count is 1 and the direction is 0, so in high mode no unsigned sample trips.
- R2: One cycle after each valid sample, `raw_flag` shows whether that sample is beyond the trip limit. With direction 0 this means strictly greater than the trip limit; with direction 1 it means strictly less than the trip limit.
- R3: While the fault flag is low, the fault flag rises one cycle after the N-th consecutive beyond-trip sample, where N is the programmed run count.
- R4: While the fault flag is low, any valid sample that is not beyond the trip limit restarts the consecutive count.
- R5: While the fault flag is high, it falls one cycle after the N-th consecutive sample inside the release limit. With direction 0, inside means less than or equal to the release limit; with direction 1, inside means greater than or equal to it. A sample that is not inside the release limit keeps the fault and restarts the count.
- R6: A programmed run count of 0 behaves as a run count of 1.
- R7: The count never wraps. The largest run count, 2^CNT_W-1, declares a fault on exactly that many consecutive samples and not one sample sooner.
- R8: A high `clr` makes both flags 0 in the next cycle and restarts the count. The configuration registers keep their values.
- R9: Both flags keep their values in every cycle that follows a cycle with neither a valid sample nor a clear, whatever `smp_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of the filter and both flags |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample reading |
| raw_flag | output | 1 | Trip comparison result of the latest sample |
| fault_flag | output | 1 | Persistence-filtered fault flag |

## Verification
The bound checker checks these rules on every cycle:
- Both flags hold steady when no sample and no clear arrive.
- A clear zeroes both flags.
- A rising fault always coincides with a beyond-trip raw flag.
- The internal count only steps up by one or returns to zero.
- A trip-limit write lands in the register.

The exact moment of declaration and release depends on a run of samples. Only the scoreboard scenarios can show this timing: runs broken one sample early, readings hovering between the two limits, exact-limit boundary values in both directions, a run count of 0, and the largest run count.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
   localparam logic [1:0] CFG_TRIP = 2'd0;
   localparam logic [1:0] CFG_REL  = 2'd1;
   localparam logic [1:0] CFG_RUN  = 2'd2;
   localparam logic [1:0] CFG_DIR  = 2'd3;

   typedef enum logic {
      DIR_HIGH = 1'b0,
      DIR_LOW  = 1'b1
   } lmon_dir_e;
endpackage

// File: rtl/lmon_cfg.sv
module lmon_cfg
   import lmon_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int CNT_W = 4,
   parameter logic [DATA_W-1:0] TRIP_INIT = '1,
   parameter logic [DATA_W-1:0] REL_INIT = '1,
   parameter logic [CNT_W-1:0] RUN_INIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] trip_lim,
   output logic [DATA_W-1:0] rel_lim,
   output logic [CNT_W-1:0]  run_len,
   output lmon_dir_e         dir
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_lim <= TRIP_INIT;
         rel_lim  <= REL_INIT;
         run_len  <= RUN_INIT;
         dir      <= DIR_HIGH;
      end else if (we) begin
         case (addr)
            CFG_TRIP: trip_lim <= wdata;
            CFG_REL:  rel_lim  <= wdata;
            CFG_RUN:  run_len  <= wdata[CNT_W-1:0];
            default:  dir      <= lmon_dir_e'(wdata[0]);
         endcase
      end
   end
endmodule

// File: rtl/lmon_cmp.sv
module lmon_cmp
   import lmon_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] trip_lim,
   input  logic [DATA_W-1:0] rel_lim,
   input  lmon_dir_e         dir,
   output logic              beyond_trip,
   output logic              inside_rel
);
   logic gt_trip, lt_trip, le_rel, ge_rel;

   generate
      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            gt_trip = $signed(data) >  $signed(trip_lim);
            lt_trip = $signed(data) <  $signed(trip_lim);
            le_rel  = $signed(data) <= $signed(rel_lim);
            ge_rel  = $signed(data) >= $signed(rel_lim);
         end
      end else begin : g_unsigned
         always_comb begin
            gt_trip = data >  trip_lim;
            lt_trip = data <  trip_lim;
            le_rel  = data <= rel_lim;
            ge_rel  = data >= rel_lim;
         end
      end
   endgenerate

   always_comb begin
      beyond_trip = (dir == DIR_LOW) ? lt_trip : gt_trip;
      inside_rel  = (dir == DIR_LOW) ? ge_rel  : le_rel;
   end
endmodule

// File: rtl/lmon_persist.sv
module lmon_persist #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             vld,
   input  logic             beyond_trip,
   input  logic             inside_rel,
   input  logic [CNT_W-1:0] run_len,
   output logic             raw_flag,
   output logic             fault_flag,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] eff_len;
   logic             toward;
   logic             reached;

   always_comb begin
      eff_len = (run_len == '0) ? CNT_ONE : run_len;
      toward  = fault_flag ? inside_rel : beyond_trip;
      reached = (cnt >= (eff_len - CNT_ONE));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         fault_flag <= 1'b0;
         raw_flag   <= 1'b0;
      end else if (clr) begin
         cnt        <= '0;
         fault_flag <= 1'b0;
         raw_flag   <= 1'b0;
      end else if (vld) begin
         raw_flag <= beyond_trip;
         if (!toward) begin
            cnt <= '0;
         end else if (reached) begin
            cnt        <= '0;
            fault_flag <= !fault_flag;
         end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/lmon_top.sv
module lmon_top
   import lmon_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int CNT_W = 4,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_data,
   output logic              raw_flag,
   output logic              fault_flag
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("lmon_top: DATA_W must be at least 2");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("lmon_top: CNT_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] trip_lim;
   logic [DATA_W-1:0] rel_lim;
   logic [CNT_W-1:0]  run_len;
   lmon_dir_e         dir;
   logic              beyond_trip;
   logic              inside_rel;
   logic [CNT_W-1:0]  persist_cnt;

   lmon_cfg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .trip_lim(trip_lim), .rel_lim(rel_lim), .run_len(run_len), .dir(dir)
   );

   lmon_cmp #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .data(smp_data), .trip_lim(trip_lim), .rel_lim(rel_lim), .dir(dir),
      .beyond_trip(beyond_trip), .inside_rel(inside_rel)
   );

   lmon_persist #(.CNT_W(CNT_W)) u_persist (
      .clk(clk), .rst_n(rst_n), .clr(clr), .vld(smp_vld),
      .beyond_trip(beyond_trip), .inside_rel(inside_rel), .run_len(run_len),
      .raw_flag(raw_flag), .fault_flag(fault_flag), .cnt(persist_cnt)
   );
endmodule

// File: rtl/lmon_chk.sv
module lmon_chk
   import lmon_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int CNT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              cfg_we,
   input logic [1:0]        cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              smp_vld,
   input logic              raw_flag,
   input logic              fault_flag,
   input logic [DATA_W-1:0] trip_lim,
   input logic [CNT_W-1:0]  cnt
);
   // R1
   trip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_TRIP) |=> (trip_lim == $past(cfg_wdata)));

   // R3
   fault_rise_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag) |-> raw_flag);

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1)));

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!fault_flag && !raw_flag));

   // R9
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(smp_vld) && !$past(clr)) |-> $stable(fault_flag));

   // R9
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(smp_vld) && !$past(clr)) |-> $stable(raw_flag));
endmodule

bind lmon_top lmon_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lmon_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .raw_flag(raw_flag),
   .fault_flag(fault_flag), .trip_lim(trip_lim), .cnt(persist_cnt)
);

// File: tb/lmon_top_tb_top.sv
module lmon_top_tb_top;
   localparam int DATA_W = 12;
   localparam int CNT_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_addr = '0;
   logic [DATA_W-1:0] cfg_wdata = '0;
   logic              smp_vld = 1'b0;
   logic [DATA_W-1:0] smp_data = '0;
   logic              raw_flag;
   logic              fault_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   int m_trip = 4095, m_rel = 4095, m_run = 1, m_dir = 0;
   int m_cnt = 0;
   bit m_fault = 1'b0, m_raw = 1'b0;

   bit    q_raw[$];
   bit    q_fault[$];
   string q_tag[$];

   always #4 clk = ~clk;

   lmon_top #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .smp_data(smp_data),
      .raw_flag(raw_flag), .fault_flag(fault_flag)
   );

   task automatic check(string tag, bit act_raw, bit act_fault, bit exp_raw, bit exp_fault);
      checks++;
      if (act_raw !== exp_raw || act_fault !== exp_fault) begin
         errors++;
         $display("FAIL %s raw=%0b fault=%0b expected raw=%0b fault=%0b",
                  tag, act_raw, act_fault, exp_raw, exp_fault);
      end
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = DATA_W'(data);
      case (addr)
         0: m_trip = data;
         1: m_rel = data;
         2: m_run = data % (1 << CNT_W);
         default: m_dir = data & 1;
      endcase
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // driver: drives one sample and pushes the expected flags
   task automatic smp(int v, string tag);
      bit out_t, in_r, toward;
      int n;
      @(negedge clk);
      smp_vld = 1'b1; smp_data = DATA_W'(v);
      out_t = (m_dir == 1) ? (v < m_trip) : (v > m_trip);
      in_r  = (m_dir == 1) ? (v >= m_rel) : (v <= m_rel);
      n = (m_run == 0) ? 1 : m_run;
      toward = m_fault ? in_r : out_t;
      if (!toward) m_cnt = 0;
      else if (m_cnt + 1 >= n) begin m_cnt = 0; m_fault = !m_fault; end
      else m_cnt++;
      m_raw = out_t;
      q_raw.push_back(m_raw); q_fault.push_back(m_fault); q_tag.push_back(tag);
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk);
      clr = 1'b1;
      m_cnt = 0; m_fault = 1'b0; m_raw = 1'b0;
      @(negedge clk);
      clr = 1'b0;
      check("R8 clear", raw_flag, fault_flag, 1'b0, 1'b0);
   endtask

   // monitor: pops expectations as results appear
   initial begin
      forever begin
         @(posedge clk);
         if (smp_vld && rst_n) begin
            @(negedge clk);
            if (q_tag.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2 unexpected result raw=%0b fault=%0b expected none", raw_flag, fault_flag);
            end else begin
               check(q_tag.pop_front(), raw_flag, fault_flag, q_raw.pop_front(), q_fault.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired raw=%0b fault=%0b expected completion", raw_flag, fault_flag);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", raw_flag, fault_flag, 1'b0, 1'b0);
      smp(4095, "R1 reset limits no trip");

      // high mode, trip 100, release 80, run 3
      wr(0, 100); wr(1, 80); wr(2, 3);
      smp(100, "R2 equal to trip is not beyond");
      smp(101, "R3 bad 1");
      smp(101, "R3 bad 2");
      smp(50,  "R4 good restarts");
      smp(101, "R4 bad 1");
      smp(101, "R4 bad 2");
      smp(101, "R3 bad 3 declares");
      smp(90,  "R5 hover holds");
      smp(80,  "R5 inside 1 (equal)");
      smp(79,  "R5 inside 2");
      smp(90,  "R5 hover restarts");
      smp(79,  "R5 inside 1");
      smp(79,  "R5 inside 2");
      smp(70,  "R5 inside 3 releases");

      // R9: idle cycles with moving data
      smp(200, "R3 bad 1 before idle");
      smp(200, "R3 bad 2 before idle");
      smp(200, "R3 declares before idle");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         smp_data = DATA_W'(i * 700);
         check("R9 idle hold", raw_flag, fault_flag, 1'b0 ^ m_raw ^ m_raw ^ 1'b1, 1'b1);
      end

      // R8: clear mid-count, config kept
      do_clr();
      smp(150, "R8 bad 1 after clear");
      smp(150, "R8 bad 2 after clear");
      do_clr();
      smp(150, "R8 count restarted 1");
      smp(150, "R8 count restarted 2");
      smp(150, "R8 limits kept declares");

      // R6: run count 0 acts as 1
      do_clr();
      wr(2, 0);
      smp(101, "R6 single bad declares");
      smp(80,  "R6 single inside releases");

      // low mode: trip below 20, release at or above 30
      wr(3, 1); wr(0, 20); wr(1, 30); wr(2, 2);
      smp(20, "R2 low equal not beyond");
      smp(19, "R3 low bad 1");
      smp(19, "R3 low bad 2 declares");
      smp(29, "R5 low hover holds");
      smp(30, "R5 low inside 1 (equal)");
      smp(4000, "R5 low inside 2 releases");

      // R7: largest run count
      wr(3, 0); wr(0, 100); wr(1, 80); wr(2, 15);
      for (int i = 0; i < 14; i++) smp(300, "R7 max run not yet");
      smp(300, "R7 max run declares");
      for (int i = 0; i < 15; i++) smp(10, "R7 max run release");

      repeat (3) @(negedge clk);
      if (q_tag.size() != 0) begin
         checks++; errors++;
         $display("FAIL R2 pending results %0d expected 0", q_tag.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule